// File: doc/BRIEF.md
# Reload Down-Counter Timer

This block is a down-counting timer with a reload register. A 16-bit control word sets it up over a simple synchronous register port. The port has an address, a write strobe, byte enables, write data and combinational read data. A count tick comes from one of three taps of a free-running prescaler, or from edges seen on an external event input. Each tick decrements the counter. When a tick arrives with the counter at zero, the timer records an underflow. In auto-reload mode it then reloads the counter and keeps running. In single-pass mode it halts until the next start command.

The underflow flag drives an interrupt request through an enable bit. A timer output either toggles on each underflow or stays high for the whole single pass. Its polarity can be inverted, and it can be gated off. While the timer is enabled, every configuration field is frozen. Only the enable, start and underflow bits can then be written.

Top module: `reload_timer`

## Requirements
- R1: After reset the control word at address 0 reads 0x0000, the counter is stopped, and the interrupt and timer outputs are 0.
- R2: Control word layout: 11:10 = tick source (00 = clock/2, 01 = clock/8, 10 = clock/32, 11 = event input); 9 = spare mode bit (stored only); 8:7 = event edge select; 6 = output enable; 5 = output invert; 4 = auto-reload; 3 = interrupt enable; 2 = underflow flag; 1 = enable; 0 = start. Bits 15:12 and the start bit always read 0.
- R3: While the enable bit reads 1, writes to bits 11:3 are ignored. Bits 2:0 remain writable.
- R4: A write to address 0, with byte 0 enabled and both bits 1 and 0 set, loads the counter from the reload register and clears the prescaler. After that the counter drops by one every D cycles, where D is the selected divide ratio.
- R5: In single-pass mode a tick with the counter at 0 sets the underflow flag and stops counting. The counter then stays at 0.
- R6: In auto-reload mode a tick with the counter at 0 sets the underflow flag and reloads the counter from the reload register. Counting continues.
- R7: Writing 0 to bit 2 clears the underflow flag, and writing 1 to it has no effect. The interrupt output is 1 exactly when the flag and the interrupt enable are both 1.
- R8: The timer output is 0 while output enable is 0. Otherwise it is the raw level XOR the invert bit. The raw level toggles on each auto-reload underflow, starting from 0 at each start. In single-pass mode it is 1 while counting.
- R9: With tick source 11, the event input goes through a two-flop synchronizer. Each synchronized edge is counted per bits 8:7: 01 = rising, 10 = falling, 11 = both, 00 = none. A change on the input reaches the counter on the third clock edge.
- R10: Address 1 is the reload register, writable byte by byte at any time. Address 2 reads the current counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address (0 control, 1 reload, 2 counter) |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| evt_in | input | 1 | External event input, asynchronous |
| irq | output | 1 | Underflow interrupt request |
| tout | output | 1 | Timer output |

## Verification
The assertions assume one thing about the register port: a start command never arrives in the same cycle as a write to the reload register. Under that assumption the value loaded into the counter is the value held before the edge. They also assume the event input is stable for at least one clock between changes, so that no edge is lost in the synchronizer. The stimulus follows both rules. It writes the reload register in a separate bus cycle before every start. It holds each event level for four clocks. Random reload values, tick sources and wait lengths stay small enough that each run finishes inside the bench's cycle budget.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    localparam logic [1:0] SRC_EVENT = 2'd3;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       spare;
        logic [1:0] edge_sel;
        logic       out_en;
        logic       out_inv;
        logic       auto_rl;
        logic       irq_en;
        logic       flag;
        logic       run;
    } ctl_t;

    function automatic logic [15:0] ctl_word(input ctl_t c);
        return {4'b0000, c.clk_sel, c.spare, c.edge_sel, c.out_en, c.out_inv,
                c.auto_rl, c.irq_en, c.flag, c.run, 1'b0};
    endfunction

endpackage

// File: rtl/rtm_prescale.sv
module rtm_prescale #(
    parameter int L0 = 1,
    parameter int L1 = 3,
    parameter int L2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PW = L2;

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] mask;

    always_comb begin
        cnt_d = clear ? '0 : cnt_q + PW'(1);
        case (sel)
            2'd0:    mask = PW'((1 << L0) - 1);
            2'd1:    mask = PW'((1 << L1) - 1);
            default: mask = PW'((1 << L2) - 1);
        endcase
        tick = (cnt_q & mask) == mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtm_evsync.sv
module rtm_evsync #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_in,
    input  logic [1:0] edge_sel,
    output logic       pulse
);
    logic [SYNC:0] sh_d, sh_q;
    logic          rise, fall;

    always_comb begin
        sh_d  = {sh_q[SYNC-1:0], evt_in};
        rise  = sh_q[SYNC-1] & ~sh_q[SYNC];
        fall  = ~sh_q[SYNC-1] & sh_q[SYNC];
        pulse = (edge_sel[0] & rise) | (edge_sel[1] & fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [1:0]    bus_be,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          evt_in,
    output logic          irq,
    output logic          tout
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        ctl_t          ctl;
        logic [DW-1:0] count;
        logic [DW-1:0] reload;
        logic          active;
        logic          tog;
    } st_t;

    st_t st_d, st_q;

    logic pre_tick, ev_pulse, src_tick;
    logic wr_ctrl, wr_lo, wr_hi, unlocked;
    logic start_req, cnt_tick, uflow;

    // aliases for the bound checker
    logic          run_q, active_q, flag_q, auto_rl_q, out_en_q;
    logic [DW-1:0] count_q, reload_q;
    logic [8:0]    locked_q;

    rtm_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_req),
        .sel   (st_q.ctl.clk_sel),
        .tick  (pre_tick)
    );

    rtm_evsync u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .edge_sel (st_q.ctl.edge_sel),
        .pulse    (ev_pulse)
    );

    always_comb begin
        st_d      = st_q;
        wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
        wr_lo     = wr_ctrl && bus_be[0];
        wr_hi     = wr_ctrl && bus_be[1];
        unlocked  = !st_q.ctl.run;
        start_req = wr_lo && bus_wdata[0] && bus_wdata[1];
        src_tick  = (st_q.ctl.clk_sel == SRC_EVENT) ? ev_pulse : pre_tick;
        cnt_tick  = st_q.ctl.run && st_q.active && src_tick;
        uflow     = cnt_tick && (st_q.count == '0);

        if (wr_hi && unlocked)
            {st_d.ctl.clk_sel, st_d.ctl.spare, st_d.ctl.edge_sel[1]} = bus_wdata[11:8];
        if (wr_lo && unlocked)
            {st_d.ctl.edge_sel[0], st_d.ctl.out_en, st_d.ctl.out_inv,
             st_d.ctl.auto_rl, st_d.ctl.irq_en} = bus_wdata[7:3];
        if (wr_lo)
            st_d.ctl.run = bus_wdata[1];

        if (wr_lo && !bus_wdata[2])
            st_d.ctl.flag = 1'b0;
        if (uflow)
            st_d.ctl.flag = 1'b1;

        if (bus_we && bus_addr == ADDR_RELOAD) begin
            if (bus_be[0]) st_d.reload[7:0]  = bus_wdata[7:0];
            if (bus_be[1]) st_d.reload[15:8] = bus_wdata[15:8];
        end

        if (cnt_tick) begin
            if (uflow) begin
                if (st_q.ctl.auto_rl) begin
                    st_d.count = st_q.reload;
                    st_d.tog   = ~st_q.tog;
                end else begin
                    st_d.active = 1'b0;
                end
            end else begin
                st_d.count = st_q.count - ONE;
            end
        end

        if (start_req) begin
            st_d.count  = st_q.reload;
            st_d.active = 1'b1;
            st_d.tog    = 1'b0;
        end
        if (!st_d.ctl.run)
            st_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = ctl_word(st_q.ctl);
            ADDR_RELOAD: bus_rdata = st_q.reload;
            ADDR_COUNT:  bus_rdata = st_q.count;
            default:     bus_rdata = '0;
        endcase
        irq  = st_q.ctl.flag && st_q.ctl.irq_en;
        tout = st_q.ctl.out_en &&
               ((st_q.ctl.auto_rl ? st_q.tog : st_q.active) ^ st_q.ctl.out_inv);

        run_q     = st_q.ctl.run;
        active_q  = st_q.active;
        flag_q    = st_q.ctl.flag;
        auto_rl_q = st_q.ctl.auto_rl;
        out_en_q  = st_q.ctl.out_en;
        count_q   = st_q.count;
        reload_q  = st_q.reload;
        locked_q  = {st_q.ctl.clk_sel, st_q.ctl.spare, st_q.ctl.edge_sel,
                     st_q.ctl.out_en, st_q.ctl.out_inv, st_q.ctl.auto_rl, st_q.ctl.irq_en};
    end
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        active,
    input logic        flag,
    input logic        auto_rl,
    input logic        out_en,
    input logic        start_req,
    input logic        cnt_tick,
    input logic        irq,
    input logic        tout,
    input logic [15:0] count,
    input logic [15:0] reload,
    input logic [8:0]  locked
);
    assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(locked));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && count != 16'd0 && !start_req) |=> count == $past(count) - 16'd1);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !start_req) |=> $stable(count));

    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && count == 16'd0 && !auto_rl && !start_req) |=> (!active && flag));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && count == 16'd0 && auto_rl) |=> (count == $past(reload) && flag));

    assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_tout_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !tout);
endmodule

bind reload_timer rtm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .active    (active_q),
    .flag      (flag_q),
    .auto_rl   (auto_rl_q),
    .out_en    (out_en_q),
    .start_req (start_req),
    .cnt_tick  (cnt_tick),
    .irq       (irq),
    .tout      (tout),
    .count     (count_q),
    .reload    (reload_q),
    .locked    (locked_q)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        evt_in = 1'b0;
    logic        irq, tout;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    reload_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq(irq), .tout(tout)
    );

    function automatic int div_of(input int sel);
        return (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
    endfunction

    function automatic logic [15:0] cfg(input int sel, input int edges, input bit oe,
                                        input bit inv, input bit rl, input bit ie);
        return 16'((sel << 10) | (edges << 7) | (int'(oe) << 6) | (int'(inv) << 5)
                   | (int'(rl) << 4) | (int'(ie) << 3));
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // program configuration while idle, then enable+start with the same low byte
    task automatic start(input logic [15:0] c, input logic [15:0] rl);
        wr(2'd0, 2'b11, 16'h0000);
        wr(2'd1, 2'b11, rl);
        wr(2'd0, 2'b11, c);
        @(negedge clk);
        bus_addr = 2'd0; bus_be = 2'b01; bus_wdata = c | 16'h0003; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 tout", {15'd0, tout}, 16'd0);

        // R2 layout: unimplemented bits, start bit and flag-set ignored
        wr(2'd0, 2'b11, 16'hFFFD);
        rd(2'd0, v); chk("R2 readback", v, 16'h0FF8);
        wr(2'd0, 2'b11, 16'h0000);
        rd(2'd0, v); chk("R2 cleared", v, 16'h0000);

        // R10 reload byte enables and counter read
        wr(2'd1, 2'b11, 16'hAAAA);
        wr(2'd1, 2'b01, 16'h1234);
        rd(2'd1, v); chk("R10 low byte", v, 16'hAA34);
        wr(2'd1, 2'b10, 16'h56FF);
        rd(2'd1, v); chk("R10 high byte", v, 16'h5634);
        rd(2'd2, v); chk("R10 count idle", v, 16'h0000);

        // R3 lock while enabled
        c = cfg(1, 0, 0, 0, 1, 0);
        start(c, 16'd50);
        wr(2'd0, 2'b11, 16'hFFFB);
        rd(2'd0, v); chk("R3 locked fields", v, c | 16'h0002);
        wr(2'd0, 2'b01, 16'h0000);
        rd(2'd0, v); chk("R3 disable only", v, c);
        wr(2'd0, 2'b11, cfg(2, 1, 1, 0, 0, 1));
        rd(2'd0, v); chk("R3 unlocked write", v, cfg(2, 1, 1, 0, 0, 1));

        // R4 random prescaler timing
        for (int i = 0; i < 8; i++) begin
            int sel = int'($urandom_range(2, 0));
            int rl  = int'($urandom_range(12, 2));
            int k   = int'($urandom_range(rl, 1));
            start(cfg(sel, 0, 0, 0, 1, 0), 16'(rl));
            edges(k * div_of(sel) - 1);
            rd(2'd2, v); chk("R4 before step", v, 16'(rl - k + 1));
            edges(1);
            rd(2'd2, v); chk("R4 after step", v, 16'(rl - k));
        end

        // R5 / R8 single pass, R7 flag and irq
        start(cfg(0, 0, 1, 0, 0, 1), 16'd3);
        edges(7);
        rd(2'd2, v); chk("R5 at zero", v, 16'd0);
        chk("R8 oneshot high", {15'd0, tout}, 16'd1);
        chk("R7 no irq yet", {15'd0, irq}, 16'd0);
        edges(1);
        rd(2'd0, v); chk("R5 flag set", {15'd0, v[2]}, 16'd1);
        chk("R8 oneshot low", {15'd0, tout}, 16'd0);
        chk("R7 irq", {15'd0, irq}, 16'd1);
        edges(10);
        rd(2'd2, v); chk("R5 stays stopped", v, 16'd0);
        wr(2'd0, 2'b01, 16'h0006);
        chk("R7 write one no effect", {15'd0, irq}, 16'd1);
        wr(2'd0, 2'b01, 16'h0002);
        chk("R7 clear", {15'd0, irq}, 16'd0);

        // R6 / R8 auto-reload toggling
        start(cfg(0, 0, 1, 0, 1, 0), 16'd2);
        edges(5);
        chk("R8 toggle before", {15'd0, tout}, 16'd0);
        edges(1);
        rd(2'd2, v); chk("R6 reloaded", v, 16'd2);
        rd(2'd0, v); chk("R6 flag", {15'd0, v[2]}, 16'd1);
        chk("R8 toggle first", {15'd0, tout}, 16'd1);
        edges(6);
        chk("R8 toggle second", {15'd0, tout}, 16'd0);

        // R8 invert and gate
        wr(2'd0, 2'b11, 16'h0000);
        wr(2'd0, 2'b11, cfg(0, 0, 1, 1, 0, 0));
        chk("R8 inverted idle", {15'd0, tout}, 16'd1);
        wr(2'd0, 2'b11, cfg(0, 0, 0, 1, 0, 0));
        chk("R8 gated", {15'd0, tout}, 16'd0);

        // R9 event counting for each edge selection
        for (int m = 0; m < 4; m++) begin
            int exp_edges = 0;
            logic lvl = 1'b0;
            evt_in = 1'b0;
            start(cfg(3, m, 0, 0, 1, 0), 16'd100);
            for (int j = 0; j < 20; j++) begin
                logic nx = 1'($urandom_range(1, 0));
                if (nx && !lvl && m[0]) exp_edges++;
                if (!nx && lvl && m[1]) exp_edges++;
                lvl = nx;
                evt_in = nx;
                edges(4);
            end
            rd(2'd2, v); chk("R9 event count", v, 16'(100 - exp_edges));
            wr(2'd0, 2'b11, 16'h0000);
            evt_in = 1'b0;
            edges(4);
        end

        // R9 latency: change reaches counter on third edge
        start(cfg(3, 1, 0, 0, 1, 0), 16'd10);
        evt_in = 1'b1;
        edges(2);
        rd(2'd2, v); chk("R9 latency before", v, 16'd10);
        edges(1);
        rd(2'd2, v); chk("R9 latency after", v, 16'd9);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule